// File: doc/BRIEF.md
# Receive Timestamp Capture Unit

This unit sits beside the receive path of one Ethernet port. It records the value of a free-running time counter at the moment each frame's start-of-frame delimiter arrives. It does this for every frame, because capture has to happen before anything is known about the frame's contents. The delimiter strobe is sampled on both edges of the reference clock. The recorded value therefore carries one extra low-order bit that says whether the falling edge saw the delimiter half a period before the rising edge that registered it.

The captured value is held while the frame streams in. At end of frame, an external classifier reports whether the frame is a time-synchronisation message for one of the supported encapsulations, and gives its 4-bit message type. The MAC reports its error flags at the same time. Only a qualifying, error-free frame produces one write into an event queue. If the queue is full at that moment, the event is lost and a sticky overflow flag records the loss.

Top module: `rts_capture`

## Requirements
- R1: A rising delimiter strobe starts a capture for every frame, whatever its type. The stored count is `time_in` as sampled at the rising clock edge that registers the delimiter.
- R2: The stored half bit is 1 when the falling edge just before that rising edge already saw the strobe high, and 0 when only the rising edge saw it.
- R3: The stored count and half bit stay unchanged from capture until the end-of-frame decision, even though `time_in` keeps moving.
- R4: A new delimiter that arrives before end of frame replaces the pending capture. The earlier frame then never produces an event.
- R5: An event is written only when `frm_ok` is high in the end-of-frame cycle and a capture is pending.
- R6: No event is written when any bit of `frm_err` is set at end of frame. The bits are: [0] too long, [1] too short, [2] MAC control frame, [3] CRC error, [4] code error, [5] alignment error.
- R7: A write is a one-cycle `evq_wr` pulse in the cycle after the end-of-frame edge. `evq_data` holds bit 0 = half bit, bits [TIME_W:1] = stored count, and bits [TIME_W+4:TIME_W+1] = message type.
- R8: When a write is due while `evq_full` is high, no write happens and `ovf_flag` is set in the following cycle.
- R9: `ovf_flag` stays set until `ovf_clr` is high. A new overflow in the same cycle as the clear takes priority, and the flag stays set.
- R10: Reset clears the pending capture and `ovf_flag`, and produces no write. An end of frame right after reset writes nothing.
- R11: An end-of-frame strobe with no capture pending is ignored.
- R12: When end of frame and a new delimiter meet on the same edge, the end of frame resolves the old capture and the new delimiter starts a fresh one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; both edges sample the delimiter |
| rst | input | 1 | Synchronous active-high reset |
| rx_sfd | input | 1 | Delimiter-detected level strobe; must return low between frames |
| time_in | input | TIME_W | Free-running time count |
| rx_eof | input | 1 | End-of-frame strobe, one cycle |
| frm_ok | input | 1 | Classifier: frame is a valid time-sync message (valid with rx_eof) |
| frm_msg | input | 4 | Classifier: message type (valid with rx_eof) |
| frm_err | input | 6 | End-of-frame error flags (valid with rx_eof) |
| evq_full | input | 1 | Event queue cannot accept a write |
| ovf_clr | input | 1 | Write-one-to-clear for the overflow flag |
| evq_wr | output | 1 | Event queue write enable |
| evq_data | output | TIME_W+5 | Event word |
| ovf_flag | output | 1 | Sticky event-lost flag |

## Verification
On every cycle, assertions check that a write never follows a full queue, an error flag, a missing classification or a missing capture. They also check that the overflow flag stays set until cleared, that a delimiter registers only once, and that the outputs are quiet after reset. Other properties need whole frame sequences, so only the bench scenarios can show them. These are the exact count and half bit stored in an event under early and late delimiter timing, the retention of that value across a long frame, the replacement of a pending capture by an early second delimiter, and the ordering when a frame ends on the same edge that a new one begins.

// File: rtl/rts_pkg.sv
`timescale 1ns/1ps
package rts_pkg;
  localparam int MSG_W = 4;
  localparam int ERR_W = 6;

  // bit index of each end-of-frame error flag
  typedef enum int {
    ERR_LONG  = 0,
    ERR_SHORT = 1,
    ERR_MACCTL = 2,
    ERR_CRC   = 3,
    ERR_CODE  = 4,
    ERR_ALIGN = 5
  } err_bit_e;
endpackage

// File: rtl/rts_edge_sampler.sv
`timescale 1ns/1ps
module rts_edge_sampler (
  input  logic clk,
  input  logic rst,
  input  logic sfd_i,
  output logic hit_o,
  output logic early_o
);
  logic fall_q;
  logic seen_q;
  logic seen;

  // falling-edge sample of the delimiter strobe
  always_ff @(negedge clk) begin
    if (rst) fall_q <= 1'b0;
    else     fall_q <= sfd_i;
  end

  assign seen = sfd_i | fall_q;

  always_ff @(posedge clk) begin
    if (rst) seen_q <= 1'b0;
    else     seen_q <= seen;
  end

  assign hit_o   = seen & ~seen_q;
  assign early_o = fall_q;

  // R1: one capture per delimiter, never on two adjacent edges
  p_single_hit_r1: assert property (@(posedge clk) disable iff (rst)
    hit_o |=> !hit_o);
endmodule

// File: rtl/rts_stamp_hold.sv
`timescale 1ns/1ps
module rts_stamp_hold #(
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit_i,
  input  logic              early_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic              eof_i,
  output logic              pend_o,
  output logic [TIME_W:0]   stamp_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o  <= 1'b0;
      stamp_o <= '0;
    end else if (hit_i) begin
      pend_o  <= 1'b1;
      stamp_o <= {time_i, early_i};
    end else if (eof_i) begin
      pend_o  <= 1'b0;
    end
  end

  // R11/R4: an end of frame without a new delimiter leaves nothing pending
  p_eof_retires_r11: assert property (@(posedge clk) disable iff (rst)
    eof_i && !hit_i |=> !pend_o);
endmodule

// File: rtl/rts_commit.sv
`timescale 1ns/1ps
module rts_commit
  import rts_pkg::*;
#(
  parameter int TIME_W = 32,
  localparam int EVT_W = TIME_W + 1 + MSG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eof_i,
  input  logic              pend_i,
  input  logic              ok_i,
  input  logic [MSG_W-1:0]  msg_i,
  input  logic [ERR_W-1:0]  err_i,
  input  logic              full_i,
  input  logic              clr_i,
  input  logic [TIME_W:0]   stamp_i,
  output logic              wr_o,
  output logic [EVT_W-1:0]  data_o,
  output logic              ovf_o
);
  logic due;
  logic clean;

  assign clean = ~|err_i;
  assign due   = eof_i & pend_i & ok_i & clean;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_o   <= 1'b0;
      data_o <= '0;
      ovf_o  <= 1'b0;
    end else begin
      wr_o  <= due & ~full_i;
      if (due && !full_i) data_o <= {msg_i, stamp_i};
      ovf_o <= (due & full_i) | (ovf_o & ~clr_i);
    end
  end

  p_no_push_full_r8: assert property (@(posedge clk) disable iff (rst)
    wr_o |-> !$past(full_i));
  p_err_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    wr_o |-> $past(err_i) == '0);
  p_cls_gate_r5: assert property (@(posedge clk) disable iff (rst)
    wr_o |-> $past(ok_i && eof_i && pend_i));
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    ovf_o && !clr_i |=> ovf_o);
endmodule

// File: rtl/rts_capture.sv
`timescale 1ns/1ps
module rts_capture
  import rts_pkg::*;
#(
  parameter int TIME_W = 32,
  localparam int EVT_W = TIME_W + 1 + MSG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_sfd,
  input  logic [TIME_W-1:0] time_in,
  input  logic              rx_eof,
  input  logic              frm_ok,
  input  logic [MSG_W-1:0]  frm_msg,
  input  logic [ERR_W-1:0]  frm_err,
  input  logic              evq_full,
  input  logic              ovf_clr,
  output logic              evq_wr,
  output logic [EVT_W-1:0]  evq_data,
  output logic              ovf_flag
);
  logic            hit;
  logic            early;
  logic            pend;
  logic [TIME_W:0] stamp;

  rts_edge_sampler u_edge (
    .clk     (clk),
    .rst     (rst),
    .sfd_i   (rx_sfd),
    .hit_o   (hit),
    .early_o (early)
  );

  rts_stamp_hold #(.TIME_W(TIME_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .hit_i   (hit),
    .early_i (early),
    .time_i  (time_in),
    .eof_i   (rx_eof),
    .pend_o  (pend),
    .stamp_o (stamp)
  );

  rts_commit #(.TIME_W(TIME_W)) u_commit (
    .clk     (clk),
    .rst     (rst),
    .eof_i   (rx_eof),
    .pend_i  (pend),
    .ok_i    (frm_ok),
    .msg_i   (frm_msg),
    .err_i   (frm_err),
    .full_i  (evq_full),
    .clr_i   (ovf_clr),
    .stamp_i (stamp),
    .wr_o    (evq_wr),
    .data_o  (evq_data),
    .ovf_o   (ovf_flag)
  );

  // R10: the first cycle out of reset is quiet
  p_reset_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !evq_wr && !ovf_flag);
endmodule

// File: tb/tb_rts_capture.sv
`timescale 1ns/1ps
module tb_rts_capture;
  localparam int TIME_W = 32;
  localparam int EVT_W  = TIME_W + 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              rx_sfd = 1'b0;
  logic [TIME_W-1:0] time_in = 32'h1000_0000;
  logic              rx_eof = 1'b0;
  logic              frm_ok = 1'b0;
  logic [3:0]        frm_msg = '0;
  logic [5:0]        frm_err = '0;
  logic              evq_full = 1'b0;
  logic              ovf_clr = 1'b0;
  logic              evq_wr;
  logic [EVT_W-1:0]  evq_data;
  logic              ovf_flag;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // model state
  bit              m_pend = 0;
  bit              m_prev = 0;
  bit              m_ovf  = 0;
  bit              m_half = 0;
  logic [TIME_W-1:0] m_stamp = '0;

  rts_capture #(.TIME_W(TIME_W)) dut (
    .clk(clk), .rst(rst), .rx_sfd(rx_sfd), .time_in(time_in),
    .rx_eof(rx_eof), .frm_ok(frm_ok), .frm_msg(frm_msg), .frm_err(frm_err),
    .evq_full(evq_full), .ovf_clr(ovf_clr),
    .evq_wr(evq_wr), .evq_data(evq_data), .ovf_flag(ovf_flag)
  );

  always #2.5 clk = ~clk;   // 200 MHz

  always @(posedge clk) time_in <= time_in + 32'd1;

  function automatic logic [EVT_W-1:0] pack_evt(input logic [3:0] m,
      input logic [TIME_W-1:0] t, input bit h);
    return {m, t, h};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock cycle; entered and left 1 ns after a rising edge
  // mode: 0 no delimiter, 1 strobe before falling edge, 2 strobe after it
  task automatic step(input int mode, input bit e, input bit c, input logic [3:0] m,
      input logic [5:0] er, input bit f, input bit cl, input string note);
    logic [TIME_W-1:0] t_exp;
    bit new_f, due, exp_wr, exp_ovf;
    logic [EVT_W-1:0] exp_d;
    string tag;
    rx_sfd = (mode == 1); rx_eof = e; frm_ok = c; frm_msg = m;
    frm_err = er; evq_full = f; ovf_clr = cl;
    @(negedge clk); #1;
    if (mode == 2) rx_sfd = 1'b1;
    t_exp  = time_in;
    new_f  = (mode != 0) && !m_prev;
    due    = e && m_pend && c && (er == 0);
    exp_wr = due && !f;
    exp_d  = pack_evt(m, m_stamp, m_half);
    exp_ovf = (due && f) ? 1'b1 : (cl ? 1'b0 : m_ovf);
    @(posedge clk); #1;
    if (e && !m_pend)      tag = "R11";
    else if (er != 0)      tag = "R6";
    else if (!c)           tag = "R5";
    else if (f)            tag = "R8";
    else                   tag = "R7";
    chk(tag, 64'(evq_wr), 64'(exp_wr));
    if (exp_wr) chk((note == "") ? "R1/R2/R3" : note, 64'(evq_data), 64'(exp_d));
    chk(cl ? "R9" : "R8", 64'(ovf_flag), 64'(exp_ovf));
    m_ovf  = exp_ovf;
    m_prev = (mode != 0);
    if (new_f) begin
      m_pend = 1; m_stamp = t_exp; m_half = (mode == 1);
    end else if (e) begin
      m_pend = 0;
    end
  endtask

  task automatic do_reset();
    rx_sfd = 0; rx_eof = 0; frm_ok = 0; frm_err = '0; evq_full = 0; ovf_clr = 0;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    m_pend = 0; m_prev = 0; m_ovf = 0;
    @(posedge clk); #1;
    chk("R10 wr", 64'(evq_wr), 64'd0);
    chk("R10 ovf", 64'(ovf_flag), 64'd0);
  endtask

  initial begin
    int unused;
    unused = $urandom(32'd4242);
    @(posedge clk); #1;
    do_reset();

    // R1/R2 early edge, long frame (R3)
    step(1, 0, 0, 4'h0, 6'h0, 0, 0, "");
    repeat (20) step(0, 0, 0, 4'h0, 6'h0, 0, 0, "");
    step(0, 1, 1, 4'h3, 6'h0, 0, 0, "R3 held");
    // R2 late edge
    step(2, 0, 0, 4'h0, 6'h0, 0, 0, "");
    step(0, 0, 0, 4'h0, 6'h0, 0, 0, "");
    step(0, 1, 1, 4'hA, 6'h0, 0, 0, "R2 late");
    // R6 each error bit
    for (int b = 0; b < 6; b++) begin
      step(1, 0, 0, 4'h0, 6'h0, 0, 0, "");
      step(0, 0, 0, 4'h0, 6'h0, 0, 0, "");
      step(0, 1, 1, 4'h1, 6'(1 << b), 0, 0, "R6");
    end
    // R5 not a time-sync frame
    step(2, 0, 0, 4'h0, 6'h0, 0, 0, "");
    step(0, 1, 0, 4'h2, 6'h0, 0, 0, "R5");
    // R4 second delimiter replaces first
    step(1, 0, 0, 4'h0, 6'h0, 0, 0, "");
    step(0, 0, 0, 4'h0, 6'h0, 0, 0, "");
    step(2, 0, 0, 4'h0, 6'h0, 0, 0, "");
    step(0, 0, 0, 4'h0, 6'h0, 0, 0, "");
    step(0, 1, 1, 4'h5, 6'h0, 0, 0, "R4 replaced");
    // R12 end and new delimiter on same edge
    step(1, 0, 0, 4'h0, 6'h0, 0, 0, "");
    step(0, 0, 0, 4'h0, 6'h0, 0, 0, "");
    step(2, 1, 1, 4'h6, 6'h0, 0, 0, "R12 old");
    step(0, 0, 0, 4'h0, 6'h0, 0, 0, "");
    step(0, 1, 1, 4'h7, 6'h0, 0, 0, "R12 new");
    // R11 stray end of frame
    step(0, 1, 1, 4'h8, 6'h0, 0, 0, "R11");
    // R8 overflow, R9 clear priority then clear
    step(1, 0, 0, 4'h0, 6'h0, 0, 0, "");
    step(0, 1, 1, 4'h9, 6'h0, 1, 0, "R8");
    step(1, 0, 0, 4'h0, 6'h0, 0, 0, "");
    step(0, 1, 1, 4'h9, 6'h0, 1, 1, "R9 priority");
    step(0, 0, 0, 4'h0, 6'h0, 0, 1, "R9 clear");
    // R10 reset discards pending capture
    step(1, 0, 0, 4'h0, 6'h0, 0, 0, "");
    do_reset();
    step(0, 1, 1, 4'h4, 6'h0, 0, 0, "R10");

    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      int md; bit e, c, f, cl; logic [5:0] er;
      md = ($urandom % 4 == 0) ? 1 + ($urandom % 2) : 0;
      e  = ($urandom % 3 == 0);
      c  = ($urandom % 4 != 0);
      er = ($urandom % 5 == 0) ? 6'(1 << ($urandom % 6)) : 6'h0;
      f  = ($urandom % 6 == 0);
      cl = ($urandom % 8 == 0);
      step(md, e, c, 4'($urandom), er, f, cl, "");
    end
    step(0, 0, 0, 4'h0, 6'h0, 0, 0, "");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule